// File: doc/BRIEF.md
# Write-Port Reservation Gate

This block sits in the decode stage of a pipeline. The pipeline's functional units have different fixed latencies, and they all share one register-file write port. Multicycle operations can finish in a different order than they were fetched. Two instructions could therefore try to write the port in the same cycle.

The block prevents that at decode. It keeps a slot map in which each bit stands for one future cycle of the write port. Each cycle the map moves one position toward the current-cycle slot. An instruction that wants to issue gives its latency. The block then looks up the single bit the instruction would need. If that slot is free, the block reserves it. If the slot is taken, the block stalls decode, and the instruction tries again in the next cycle with the same latency.

A flush mask lets the pipeline release the slots held by squashed instructions. Every write-port structural check in the pipeline happens here, in one lookup.

Top module: `wpr_port_reserve`

## Requirements
- R1: While reset is asserted and right after it, the reservation vector is all zero, and both port_busy and stall are 0.
- R2: With no issue and a zero flush mask, the next cycle's reservation vector is the current one shifted one position toward bit 0. Bit 0 drops out and a zero enters at the top (bit SLOTS-1).
- R3: An issue with latency L (1 to SLOTS-1) that does not stall sets bit L-1 of the next cycle's vector. port_busy then rises exactly L cycles after the issue cycle.
- R4: An issue whose slot is taken stalls. It adds no bit, and the vector only shifts.
- R5: A stalled instruction that is presented again in the next cycle with the same latency is checked against the shifted vector. It is granted as soon as its slot is free.
- R6: The conflict check uses the position a bit will have after this cycle's shift. An existing bit at position L blocks latency L. A bit at position L-1 does not block latency L.
- R7: Every bit that is set in flush_mask clears the same bit position of the current vector before the shift. The conflict check in that cycle uses the cleared vector.
- R8: An issue with latency 0 stalls and sets no bit.
- R9: port_busy equals bit 0 of the current reservation vector.
- R10: When issue_valid is 0, stall is 0 and no bit is added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_valid | input | 1 | An instruction in decode wants to issue |
| issue_lat | input | LAT_W | Cycles from issue until its register-file write |
| flush_mask | input | SLOTS | Slot positions of squashed instructions to release |
| stall | output | 1 | Hold the instruction in decode this cycle |
| resv_vec | output | SLOTS | Current reservation vector; bit i means the port is used i cycles from now |
| port_busy | output | 1 | The write port is used in the current cycle |

## Verification
The bench builds the block with its defaults: SLOTS = 16 and LAT_W = 4. With these values every legal latency from 1 to 15 can be driven, along with the illegal value 0. The top slot, bit 15, can never be reserved, so the bench can check that the zero entering at the top stays zero. A 4-bit latency input also keeps a random draw dense enough that conflicts, repeated stalls and flushes of live reservations happen often. The directed cases cover the position-L versus position-L-1 boundary and the retry of a stalled instruction.

// File: rtl/wpr_pkg.sv
package wpr_pkg;
    // Default number of write-port slots tracked ahead of the current cycle.
    localparam int unsigned WPR_SLOTS_DEF = 16;
    localparam int unsigned WPR_LAT_W_DEF = $clog2(WPR_SLOTS_DEF);
endpackage

// File: rtl/wpr_lat_decode.sv
module wpr_lat_decode #(
    parameter int unsigned SLOTS = wpr_pkg::WPR_SLOTS_DEF,
    parameter int unsigned LAT_W = $clog2(SLOTS)
) (
    input  logic [LAT_W-1:0] lat,
    output logic [SLOTS-1:0] slot_onehot,
    output logic             lat_legal
);
    // A latency of L lands in position L-1 once this cycle's shift is applied.
    genvar gi;
    generate
        for (gi = 0; gi < SLOTS - 1; gi++) begin : g_slot
            assign slot_onehot[gi] = (lat == LAT_W'(gi + 1));
        end
    endgenerate
    assign slot_onehot[SLOTS-1] = 1'b0;

    assign lat_legal = (lat != '0) && ({1'b0, lat} < (LAT_W+1)'(SLOTS));

    always_comb begin
        assert (!lat_legal || $onehot(slot_onehot))
            else $error("assert_legal_onehot_R3");
    end
endmodule

// File: rtl/wpr_slot_map.sv
module wpr_slot_map #(
    parameter int unsigned SLOTS = wpr_pkg::WPR_SLOTS_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SLOTS-1:0] flush_mask,
    input  logic [SLOTS-1:0] grant_onehot,
    output logic [SLOTS-1:0] vec_q,
    output logic [SLOTS-1:0] shifted
);
    typedef struct packed {
        logic [SLOTS-1:0] vec;
    } map_t;

    map_t st_d, st_q;

    always_comb begin
        shifted  = (st_q.vec & ~flush_mask) >> 1;
        st_d.vec = shifted | grant_onehot;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vec_q = st_q.vec;

    // The top slot can only be filled by an explicit reservation, never by the shift.
    assert_top_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_onehot[SLOTS-1] |=> !vec_q[SLOTS-1]);
endmodule

// File: rtl/wpr_port_reserve.sv
module wpr_port_reserve #(
    parameter int unsigned SLOTS = wpr_pkg::WPR_SLOTS_DEF,
    parameter int unsigned LAT_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_valid,
    input  logic [LAT_W-1:0] issue_lat,
    input  logic [SLOTS-1:0] flush_mask,
    output logic             stall,
    output logic [SLOTS-1:0] resv_vec,
    output logic             port_busy
);
    logic [SLOTS-1:0] slot_onehot;
    logic             lat_legal;
    logic [SLOTS-1:0] shifted;
    logic [SLOTS-1:0] grant_onehot;
    logic             conflict;

    wpr_lat_decode #(.SLOTS(SLOTS), .LAT_W(LAT_W)) u_dec (
        .lat         (issue_lat),
        .slot_onehot (slot_onehot),
        .lat_legal   (lat_legal)
    );

    wpr_slot_map #(.SLOTS(SLOTS)) u_map (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush_mask   (flush_mask),
        .grant_onehot (grant_onehot),
        .vec_q        (resv_vec),
        .shifted      (shifted)
    );

    always_comb begin
        conflict     = |(shifted & slot_onehot);
        stall        = issue_valid && (!lat_legal || conflict);
        grant_onehot = (issue_valid && !stall) ? slot_onehot : '0;
    end

    assign port_busy = resv_vec[0];

    assert_idle_no_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |-> !stall);

    assert_lat_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_lat == '0) |-> stall);

    assert_stall_adds_none_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!issue_valid || stall) |=> $countones(resv_vec) == $past($countones((resv_vec & ~flush_mask) >> 1)));

    assert_grant_adds_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !stall) |=> $countones(resv_vec) == $past($countones((resv_vec & ~flush_mask) >> 1)) + 1);

    assert_busy_bit0_R9: assert property (@(posedge clk) disable iff (!rst_n)
        port_busy == resv_vec[0]);
endmodule

// File: tb/sim_wpr_port_reserve.sv
`timescale 1ns/1ps
module sim_wpr_port_reserve;
    localparam int SLOTS = 16;
    localparam int LAT_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             issue_valid = 1'b0;
    logic [LAT_W-1:0] issue_lat = '0;
    logic [SLOTS-1:0] flush_mask = '0;
    logic             stall;
    logic [SLOTS-1:0] resv_vec;
    logic             port_busy;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    logic [SLOTS-1:0] model = '0;
    string vec_tag = "R2";

    always #5 clk = ~clk;

    wpr_port_reserve #(.SLOTS(SLOTS), .LAT_W(LAT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_lat(issue_lat),
        .flush_mask(flush_mask), .stall(stall), .resv_vec(resv_vec), .port_busy(port_busy)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit exp_stall(logic [SLOTS-1:0] m, bit v, int lat, logic [SLOTS-1:0] fm);
        logic [SLOTS-1:0] sh;
        sh = (m & ~fm) >> 1;
        if (!v) return 0;
        if (lat == 0 || lat >= SLOTS) return 1;
        return sh[lat-1];
    endfunction

    function automatic logic [SLOTS-1:0] next_model(logic [SLOTS-1:0] m, bit v, int lat, logic [SLOTS-1:0] fm);
        logic [SLOTS-1:0] r;
        r = (m & ~fm) >> 1;
        if (v && !exp_stall(m, v, lat, fm)) r[lat-1] = 1'b1;
        return r;
    endfunction

    // One cycle: drive at negedge, check before the next posedge, update model.
    task automatic step(input bit v, input int lat, input logic [SLOTS-1:0] fm, input string stag);
        bit es;
        @(negedge clk);
        issue_valid = v;
        issue_lat   = LAT_W'(lat);
        flush_mask  = fm;
        #1;
        es = exp_stall(model, v, lat, fm);
        chk(resv_vec == model, vec_tag, 32'(resv_vec), 32'(model));
        chk(port_busy == model[0], "R9", 32'(port_busy), 32'(model[0]));
        chk(stall == es, stag, 32'(stall), 32'(es));
        if (fm != '0) vec_tag = "R7";
        else if (v && !es) vec_tag = "R3";
        else if (v) vec_tag = "R4";
        else vec_tag = "R2";
        model = next_model(model, v, lat, fm);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0C1A));
        // R1: reset state
        repeat (2) @(negedge clk);
        chk(resv_vec == '0, "R1", 32'(resv_vec), 0);
        chk(port_busy == 1'b0, "R1", 32'(port_busy), 0);
        chk(stall == 1'b0, "R1", 32'(stall), 0);
        rst_n = 1'b1;

        // R3: latency 3, busy rises three cycles later
        step(1, 3, '0, "R3");
        step(0, 0, '0, "R10");
        step(0, 0, '0, "R2");
        @(negedge clk); #1;
        chk(port_busy == 1'b1, "R3", 32'(port_busy), 1);
        model = model >> 1;
        vec_tag = "R2";

        // R6: bit at position L blocks L, position L-1 does not
        step(1, 5, '0, "R3");   // next vector: bit 4
        step(1, 4, '0, "R6");   // bit 4 moves to 3 = needed slot: stall
        step(1, 4, '0, "R5");   // bit now 3 -> 2; slot 3 free: granted
        step(1, 3, '0, "R6");   // bit at 3 (lat4) -> 2: blocks lat 3
        step(1, 3, '0, "R6");   // lat-4 bit now at 2, only blocks lat 2 next
        // R8: latency 0 always stalls
        step(1, 0, '0, "R8");
        // R7: flush clears live slots and frees a conflict
        step(1, 9, '0, "R3");
        step(1, 8, 16'h0100, "R7");
        step(0, 0, 16'hFFFF, "R10");
        step(0, 0, '0, "R2");

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            bit v;
            int lat;
            logic [SLOTS-1:0] fm;
            v   = ($urandom % 4) != 0;
            lat = $urandom % SLOTS;
            fm  = (($urandom % 16) == 0) ? SLOTS'($urandom) : '0;
            step(v, lat, fm, !v ? "R10" : (lat == 0 ? "R8" : (fm != '0 ? "R7" : "R4")));
        end
        step(0, 0, '0, "R2");

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule